// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a byte-wide memory device whose top eight addresses form a calendar clock. Every location below those eight is plain read/write storage. The top eight hold a control byte and seven clock/calendar registers. The clock registers use BCD and hours count in 24-hour form. Host logic reaches the block through an asynchronous-SRAM-style strobe set: active-low chip enable, write enable and output enable, an address and a byte of data. The read data comes out on a separate output with a drive-enable flag, which keeps the port free of tristate nets. A one-cycle pulse on `sec_pulse` marks each elapsed second.

The time is held twice. The running counters advance on each second pulse. The registers the bus sees are a separate copy, refreshed from the counters one cycle after each pulse. Two freeze bits in the control byte stop that refresh. The read-freeze bit gives a coherent snapshot while the counters keep running. The write-freeze bit opens the time registers for writing, and clearing it copies the written values into the counters. A stop bit in the seconds register halts counting. This bit is set out of reset.

The address width is a parameter. At `ADDR_W` = 15 the space is 32 KB, with 32,760 storage bytes below the clock. The default of 11 keeps the storage array small.

Top module: `bcd_rtc`

## Requirements
- R1: Addresses below `2**ADDR_W - 8` are storage bytes: a write stores `wr_byte` and a later read returns it.
- R2: A write happens only on a clock edge with `ce_n`=0 and `we_n`=0. `rd_en` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. When `rd_en` is 0, `rd_byte` is 0.
- R3: Clock offsets from base `2**ADDR_W - 8` are: 0 control, 1 seconds (bit 7 = stop bit), 2 minutes, 3 hours (00-23), 4 day of week (1-7), 5 date, 6 month, 7 year (00-99). All clock values are two-digit BCD.
- R4: After reset the registers read as follows: control 0x00, seconds 0x80, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00.
- R5: While the stop bit (seconds bit 7) is 1, second pulses do not advance the time. Once the bit is written 0, each pulse advances it again. The stop bit can be written whatever the state of the write-freeze bit.
- R6: When neither freeze bit is set, the visible time registers show the advanced counters one clock cycle after the cycle in which a pulse is sampled.
- R7: While control bit 6 (read-freeze) is 1, the visible time registers hold still, but the counters keep counting. After the bit is cleared, the next pulse shows the fully advanced time.
- R8: Writes to time registers (seconds bits 6:0 and offsets 2-7) take effect only while control bit 7 (write-freeze) is 1. Otherwise they are ignored.
- R9: A control write that changes bit 7 from 1 to 0 loads the counters from the visible registers in that cycle. Any pulse sampled in that same cycle is dropped.
- R10: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00. A day carry steps the day of week (7 wraps to 1) and the date. Month wraps from 12 to 01, and year from 99 to 00.
- R11: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. Month 02 has 29 days when the year is divisible by 4 and 28 days otherwise.
- R12: Control bits 5:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wr_byte | input | 8 | Write data |
| rd_byte | output | 8 | Read data, zero when not driven |
| rd_en | output | 1 | Read data is valid and would drive the bus |
| sec_pulse | input | 1 | One-cycle pulse per elapsed second |

## Verification
A wrong carry in the counters only shows up when the affected field is read back after a pulse. It appears one cycle after that pulse, and only if no freeze bit is set. For this reason the bench reads all seven registers after the crossings it drives at the minute, hour, day, month and year boundaries. A bad freeze or load path shows up either as a snapshot that moves while read-freeze is set, or as a time that does not continue from the written values after write-freeze is released. Either fault is visible at the first read after the next pulse. Stop-bit faults are caught the same way, because the seconds value must stay unchanged across a pulse while the bit is set.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_byte,
  output logic [7:0]        rd_byte,
  output logic              rd_en,
  input  logic              sec_pulse
);
  localparam int DEPTH = 2**ADDR_W - 8;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DEPTH);
  localparam logic [7:1][7:0] CNT_INIT = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [7:0] mem [DEPTH];
  logic [7:0] ctrl;
  logic [7:1][7:0] cnt, vis;
  logic pend;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    if (v == hi) return lo;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mo, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mo)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  wire wr      = !ce_n && !we_n;
  wire rd      = !ce_n && !oe_n && we_n;
  wire in_clk  = addr >= BASE;
  wire [2:0] off = addr[2:0];
  wire stopped = vis[1][7];
  wire frozen  = ctrl[7] | ctrl[6];
  wire release_w = wr && in_clk && off == 3'd0 && ctrl[7] && !wr_byte[7];
  wire step    = sec_pulse && !stopped && !release_w;

  wire [7:0] mend = month_end(cnt[6], cnt[7]);
  wire c_s  = cnt[1][6:0] == 7'h59;
  wire c_m  = c_s && cnt[2] == 8'h59;
  wire c_h  = c_m && cnt[3] == 8'h23;
  wire c_d  = c_h && cnt[5] == mend;
  wire c_mo = c_d && cnt[6] == 8'h12;

  wire [7:0][7:0] view = {vis, ctrl};
  assign rd_en   = rd;
  assign rd_byte = !rd ? 8'h00 : in_clk ? view[off] : mem[addr];

  always_ff @(posedge clk)
    if (wr && !in_clk) mem[addr] <= wr_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= 8'h00;
      cnt  <= CNT_INIT;
      vis  <= CNT_INIT;
      vis[1][7] <= 1'b1;
      pend <= 1'b0;
    end else begin
      pend <= step;
      if (release_w) begin
        cnt <= vis;
        cnt[1][7] <= 1'b0;
      end else if (step) begin
        cnt[1] <= bcd_inc(cnt[1], 8'h00, 8'h59);
        if (c_s) cnt[2] <= bcd_inc(cnt[2], 8'h00, 8'h59);
        if (c_m) cnt[3] <= bcd_inc(cnt[3], 8'h00, 8'h23);
        if (c_h) begin
          cnt[4] <= bcd_inc(cnt[4], 8'h01, 8'h07);
          cnt[5] <= bcd_inc(cnt[5], 8'h01, mend);
        end
        if (c_d)  cnt[6] <= bcd_inc(cnt[6], 8'h01, 8'h12);
        if (c_mo) cnt[7] <= bcd_inc(cnt[7], 8'h00, 8'h99);
      end
      if (pend && !frozen) begin
        vis[7:2]    <= cnt[7:2];
        vis[1][6:0] <= cnt[1][6:0];
      end
      if (wr && in_clk) begin
        if (off == 3'd0) ctrl <= wr_byte;
        else if (off == 3'd1) begin
          vis[1][7] <= wr_byte[7];
          if (ctrl[7]) vis[1][6:0] <= wr_byte[6:0];
        end else if (ctrl[7]) vis[off] <= wr_byte;
      end
    end
  end

  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !release_w) |=> $stable(cnt));
  p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !(wr && in_clk)) |=> $stable(vis));
  p_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !frozen && !(wr && in_clk)) |=> vis[2] == $past(cnt[2]));
  p_release_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> cnt[3] == $past(vis[3]));
  p_ignore_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_clk && off == 3'd2 && !ctrl[7] && !(pend && !frozen)) |=> $stable(vis[2]));
  p_sec_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt[1][6:0] == 7'h59) |=> cnt[1][6:0] == 7'h00);
  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (rd_byte == 8'h00 && !rd_en));
endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  localparam int ADDR_W = 11;
  localparam int BASE = 2**ADDR_W - 8;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, sec_pulse = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wr_byte = '0, rd_byte;
  logic rd_en;
  int total = 0, fails = 0;
  int s, m, h, dw, dt, mo, yr;
  logic osc;
  logic [7:0] cal;
  logic [7:0] snap [1:7];
  logic [ADDR_W-1:0] saddr [12];
  logic [7:0] sdata [12];

  bcd_rtc #(.ADDR_W(ADDR_W)) uut (.clk, .rst_n, .ce_n, .we_n, .oe_n, .addr,
    .wr_byte, .rd_byte, .rd_en, .sec_pulse);

  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int dim(input int mn, input int y);
    if (mn == 2) return (y % 4 == 0) ? 29 : 28;
    if (mn == 4 || mn == 6 || mn == 9 || mn == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expb(input int i);
    case (i)
      1: return {osc, bcd(s)[6:0]};
      2: return bcd(m);
      3: return bcd(h);
      4: return bcd(dw);
      5: return bcd(dt);
      6: return bcd(mo);
      default: return bcd(yr);
    endcase
  endfunction

  task automatic adv();
    if (osc) return;
    s++;
    if (s == 60) begin s = 0; m++; end else return;
    if (m == 60) begin m = 0; h++; end else return;
    if (h == 24) begin h = 0; dw = (dw == 7) ? 1 : dw + 1; dt++; end else return;
    if (dt > dim(mo, yr)) begin dt = 1; mo++; end else return;
    if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wr_byte = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic bread(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 0; oe_n = 0; we_n = 1;
    #2 d = rd_byte;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_pulse = 1;
      @(negedge clk); sec_pulse = 0;
      @(negedge clk);
      adv();
    end
  endtask

  task automatic verify(input string req);
    logic [7:0] v;
    for (int i = 1; i < 8; i++) begin
      bread(BASE + i, v);
      check(req, v, expb(i));
    end
  endtask

  task automatic set_time(input int ny, input int nmo, input int ndt, input int ndw,
                          input int nh, input int nm, input int ns);
    bwrite(BASE, 8'h80 | cal);
    bwrite(BASE + 1, bcd(ns));
    bwrite(BASE + 2, bcd(nm));
    bwrite(BASE + 3, bcd(nh));
    bwrite(BASE + 4, bcd(ndw));
    bwrite(BASE + 5, bcd(ndt));
    bwrite(BASE + 6, bcd(nmo));
    bwrite(BASE + 7, bcd(ny));
    bwrite(BASE, cal);
    yr = ny; mo = nmo; dt = ndt; dw = ndw; h = nh; m = nm; s = ns; osc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    n = $urandom(32'd4711);
    s = 0; m = 0; h = 0; dw = 1; dt = 1; mo = 1; yr = 0; osc = 1; cal = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R4 reset values, R3 map
    bread(BASE, v); check("R4 ctrl", v, 8'h00);
    verify("R4 reset");

    // R1 storage, random
    for (int i = 0; i < 12; i++) begin
      saddr[i] = ADDR_W'(i * 150 + ($urandom % 100));
      sdata[i] = 8'($urandom);
      bwrite(int'(saddr[i]), sdata[i]);
    end
    for (int i = 0; i < 12; i++) begin
      bread(int'(saddr[i]), v); check("R1 storage", v, sdata[i]);
    end
    bwrite(BASE - 1, 8'hA5); bread(BASE - 1, v); check("R1 top storage", v, 8'hA5);

    // R2 qualification
    @(negedge clk); addr = saddr[0]; wr_byte = ~sdata[0]; ce_n = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    bread(int'(saddr[0]), v); check("R2 write without ce", v, sdata[0]);
    @(negedge clk); addr = saddr[1]; ce_n = 0; oe_n = 1; we_n = 1;
    #2 check("R2 no oe rd_en", {7'd0, rd_en}, 8'h00); check("R2 no oe data", rd_byte, 8'h00);
    ce_n = 1;
    @(negedge clk); addr = saddr[1]; wr_byte = sdata[1]; ce_n = 0; oe_n = 0; we_n = 0;
    #2 check("R2 write blocks rd_en", {7'd0, rd_en}, 8'h00);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;

    // R8 ignored time write, R5 stopped clock ignores pulses
    bwrite(BASE + 2, 8'h33);
    bread(BASE + 2, v); check("R8 ignored minute write", v, 8'h00);
    pulse(2);
    verify("R5 stopped");

    // R12 cal bits, set time, R9 load, R11 leap Feb
    cal = 8'h15;
    set_time(24, 2, 28, 3, 23, 59, 58);
    bread(BASE, v); check("R12 ctrl readback", v, 8'h15);
    verify("R9 written values");
    pulse(1); verify("R9 R6 continue from load");
    pulse(1); verify("R10 R11 day carry into leap day");

    set_time(24, 2, 29, 4, 23, 59, 59);
    pulse(1); verify("R11 leap day to March");
    set_time(23, 2, 28, 2, 23, 59, 59);
    pulse(1); verify("R11 non-leap Feb end");
    set_time(21, 4, 30, 5, 23, 59, 59);
    pulse(1); verify("R11 30-day month end");
    set_time(99, 12, 31, 7, 23, 59, 59);
    pulse(1); verify("R10 year and dow wrap");
    set_time(5, 6, 14, 2, 10, 59, 59);
    pulse(1); verify("R10 hour carry");

    // R7 read freeze
    bwrite(BASE, 8'h40 | cal);
    for (int i = 1; i < 8; i++) snap[i] = expb(i);
    pulse(3);
    for (int i = 1; i < 8; i++) begin
      bread(BASE + i, v); check("R7 frozen snapshot", v, snap[i]);
    end
    bwrite(BASE, cal);
    pulse(1); verify("R7 resume after freeze");

    // R5 stop bit writable without write-freeze, then restart
    bwrite(BASE + 1, 8'hC4);
    osc = 1;
    pulse(2);
    verify("R5 stop bit set");
    bwrite(BASE + 1, 8'h00);
    osc = 0;
    pulse(1); verify("R5 restart");

    // random pulse runs
    for (int it = 0; it < 40; it++) begin
      n = $urandom % 4;
      pulse(n);
      verify("R6 R10 random run");
    end
    bread(BASE, v); check("R12 ctrl final", v, 8'h15);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule